// File: doc/BRIEF.md
# Rotate-Through-Link and Arithmetic Shift Unit

This unit carries out the shift group of a 16-bit accumulator machine. When the execute strobe is high, it decodes the instruction word and applies one of four moves to the accumulator value and the link bit on its inputs. The four moves are a left rotate through the link, a right rotate through the link, a left arithmetic shift and a right arithmetic shift. Each move goes one, two or three places.

The rotates treat the link and the accumulator as a single 17-bit ring. The arithmetic shifts hold the sign bit in place and leave the link as it is. The result is formed in one combinational pass and stored one clock after the strobe, so a three-place move takes no more time than a one-place move. A zero count, or a word outside the group, is flagged as illegal, and the accumulator and link values pass through unchanged.

Top module: `acc_rotshift`

## Requirements
- R1: While reset is low, and after it is released until the first strobe, `ac_o` and `link_o` read 0, and `done_o` and `illegal_o` are low.
- R2: An instruction belongs to the group when bits 15..6 equal octal 030 and bits 3..2 are zero. Bits 5..4 select the move: 00 rotate left, 01 rotate right, 10 arithmetic left, 11 arithmetic right. Bits 1..0 give the count.
- R3: A rotate left repeats the following step `count` times: AC bit 15 goes into the link, and the old link goes into AC bit 0.
- R4: A rotate right repeats the following step `count` times: AC bit 0 goes into the link, and the old link goes into AC bit 15.
- R5: An arithmetic left shift keeps AC bit 15. It shifts bits 14..0 left by the count, fills with zeros, and drops the bits that would reach bit 15.
- R6: An arithmetic right shift copies the sign bit into every vacated upper position, once for each step of the count.
- R7: The arithmetic shifts leave the link equal to `link_i`.
- R8: A group instruction with count 0 raises `illegal_o`, and `ac_o`/`link_o` take the unchanged `ac_i`/`link_i`.
- R9: A word outside the group is treated as in R8: it is flagged illegal and the values pass through unchanged.
- R10: `done_o` is high for exactly the one clock after each strobe clock, for every count. The result is valid in that same clock, and `illegal_o` is only high together with `done_o`.
- R11: Without a strobe, `ac_o` and `link_o` hold their values, and `done_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_i | input | 1 | Execute strobe, one clock per instruction |
| instr_i | input | 16 | Instruction word |
| ac_i | input | 16 | Accumulator value before the instruction |
| link_i | input | 1 | Link value before the instruction |
| ac_o | output | 16 | Accumulator after the instruction |
| link_o | output | 1 | Link after the instruction |
| done_o | output | 1 | Result valid, one clock after the strobe |
| illegal_o | output | 1 | Instruction was illegal (zero count or outside the group) |

## Verification
The assertions check the following on every clock:
- The done timing, and that `illegal_o` is never high without `done_o`.
- The output is held when there is no strobe.
- Illegal words pass through unchanged.
- The arithmetic shifts keep the link and the sign bit.
- A rotate conserves the number of ones in the 17-bit ring.

The assertions cannot show where each bit lands for a given count. Only the bench scenarios show that: they compare every result against a step-by-step model across all counts, sign and link patterns, and a run of back-to-back strobes.

// File: rtl/acc_rotshift.sv
module acc_rotshift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         exec_i,
  input  logic [15:0]  instr_i,
  input  logic [W-1:0] ac_i,
  input  logic         link_i,
  output logic [W-1:0] ac_o,
  output logic         link_o,
  output logic         done_o,
  output logic         illegal_o
);
  localparam logic [9:0] GROUP = 10'o030;
  localparam int MAXCNT = 3;

  logic [1:0] op, cnt;
  logic       legal;
  logic [W:0] ring_l, ring_r;
  logic [W-1:0] nxt_ac;
  logic         nxt_l;

  assign op    = instr_i[5:4];
  assign cnt   = instr_i[1:0];
  assign legal = (instr_i[15:6] == GROUP) && (instr_i[3:2] == 2'b00) && (cnt != 2'd0);

  always_comb begin
    ring_l = {link_i, ac_i};
    ring_r = {link_i, ac_i};
    for (int i = 0; i < MAXCNT; i++) begin
      if (i < int'(cnt)) begin
        ring_l = {ring_l[W-1:0], ring_l[W]};
        ring_r = {ring_r[0], ring_r[W:1]};
      end
    end
    nxt_ac = ac_i;
    nxt_l  = link_i;
    case (op)
      2'b00: {nxt_l, nxt_ac} = ring_l;
      2'b01: {nxt_l, nxt_ac} = ring_r;
      2'b10: nxt_ac = {ac_i[W-1], ac_i[W-2:0] << cnt};
      default: nxt_ac = W'($signed(ac_i) >>> cnt);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac_o      <= '0;
      link_o    <= 1'b0;
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      done_o    <= exec_i;
      illegal_o <= exec_i && !legal;
      if (exec_i) begin
        ac_o   <= legal ? nxt_ac : ac_i;
        link_o <= legal ? nxt_l  : link_i;
      end
    end
  end
endmodule

// File: rtl/acc_rotshift_chk.sv
module acc_rotshift_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         exec_i,
  input logic [15:0]  instr_i,
  input logic [W-1:0] ac_i,
  input logic         link_i,
  input logic [W-1:0] ac_o,
  input logic         link_o,
  input logic         done_o,
  input logic         illegal_o
);
  logic in_grp, is_rot, is_shift;
  assign in_grp   = instr_i[15:6] == 10'o030 && instr_i[3:2] == 2'b00 && instr_i[1:0] != 2'b00;
  assign is_rot   = in_grp && !instr_i[5];
  assign is_shift = in_grp && instr_i[5];

  // R10
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n) exec_i |=> done_o);
  // R10
  no_idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n) !exec_i |=> !done_o);
  // R10
  illegal_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n) illegal_o |-> done_o);
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |=> $stable(ac_o) && $stable(link_o));
  // R8
  illegal_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && !in_grp |=> illegal_o && ac_o == $past(ac_i) && link_o == $past(link_i));
  // R7
  shift_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && is_shift |=> link_o == $past(link_i) && !illegal_o);
  // R5
  shift_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && is_shift |=> ac_o[W-1] == $past(ac_i[W-1]));
  // R3
  rot_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && is_rot |=> $countones({link_o, ac_o}) == $past($countones({link_i, ac_i})));
endmodule

bind acc_rotshift acc_rotshift_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .instr_i(instr_i), .ac_i(ac_i),
  .link_i(link_i), .ac_o(ac_o), .link_o(link_o), .done_o(done_o), .illegal_o(illegal_o)
);

// File: tb/sim_acc_rotshift.sv
module sim_acc_rotshift;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [15:0] ac_i = '0;
  logic        link_i = 1'b0;
  logic [15:0] ac_o;
  logic        link_o, done_o, illegal_o;

  int checks = 0;
  int fails  = 0;

  typedef struct packed { logic [15:0] ac; logic l; logic ill; } exp_t;
  exp_t q[$];
  string tagq[$];
  logic [15:0] last_ac = '0;
  logic        last_l  = 1'b0;
  logic        quit = 1'b0;

  always #2 clk = ~clk;

  acc_rotshift u0 (
    .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .instr_i(instr_i), .ac_i(ac_i),
    .link_i(link_i), .ac_o(ac_o), .link_o(link_o), .done_o(done_o), .illegal_o(illegal_o)
  );

  function automatic logic [15:0] mk(input logic [1:0] op, input logic [1:0] n);
    return {10'o030, op, 2'b00, n};
  endfunction

  function automatic exp_t model(input logic [15:0] ins, input logic [15:0] a, input logic l);
    exp_t e;
    logic t;
    e.ac = a; e.l = l; e.ill = 1'b0;
    if (ins[15:6] != 10'o030 || ins[3:2] != 2'b00 || ins[1:0] == 2'b00) begin
      e.ill = 1'b1;
      return e;
    end
    for (int s = 0; s < int'(ins[1:0]); s++) begin
      case (ins[5:4])
        2'b00: begin t = e.ac[15]; e.ac = {e.ac[14:0], e.l}; e.l = t; end
        2'b01: begin t = e.ac[0];  e.ac = {e.l, e.ac[15:1]}; e.l = t; end
        2'b10: e.ac = {e.ac[15], e.ac[13:0], 1'b0};
        default: e.ac = {e.ac[15], e.ac[15:1]};
      endcase
    end
    return e;
  endfunction

  task automatic issue(input logic [15:0] ins, input logic [15:0] a, input logic l, input string tag);
    @(negedge clk);
    instr_i = ins; ac_i = a; link_i = l; exec_i = 1'b1;
    q.push_back(model(ins, a, l));
    tagq.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      exec_i = 1'b0;
      instr_i = $urandom; ac_i = $urandom; link_i = 1'b1;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !quit) begin
      if (done_o) begin
        if (q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R10: done_o high with nothing expected (actual 1, expected 0)");
        end else begin
          exp_t e;
          string tg;
          e = q.pop_front();
          tg = tagq.pop_front();
          checks++;
          if (ac_o !== e.ac || link_o !== e.l || illegal_o !== e.ill) begin
            fails++;
            $display("FAIL %s: ac=%h l=%b ill=%b, expected ac=%h l=%b ill=%b",
                     tg, ac_o, link_o, illegal_o, e.ac, e.l, e.ill);
          end
          last_ac = e.ac; last_l = e.l;
        end
      end else if (q.size() == 0) begin
        checks++;
        if (ac_o !== last_ac || link_o !== last_l || illegal_o !== 1'b0) begin
          fails++;
          $display("FAIL R11: ac=%h l=%b ill=%b, expected ac=%h l=%b ill=0",
                   ac_o, link_o, illegal_o, last_ac, last_l);
        end
      end
    end
  end

  initial begin
    #20000;
    if (!quit) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (ac_o !== 16'h0 || link_o !== 1'b0 || done_o !== 1'b0 || illegal_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: ac=%h l=%b done=%b ill=%b, expected all zero", ac_o, link_o, done_o, illegal_o);
    end
    rst_n = 1'b1;
    idle(2);
    // R3 rotate left, all counts
    issue(mk(2'b00, 2'd1), 16'h8000, 1'b1, "R3 ral1");
    issue(mk(2'b00, 2'd2), 16'hC001, 1'b0, "R3 ral2");
    issue(mk(2'b00, 2'd3), 16'hA5A5, 1'b1, "R3 ral3");
    idle(2);
    // R4 rotate right
    issue(mk(2'b01, 2'd1), 16'h0001, 1'b0, "R4 rar1");
    issue(mk(2'b01, 2'd2), 16'h0003, 1'b1, "R4 rar2");
    issue(mk(2'b01, 2'd3), 16'h1234, 1'b1, "R4 rar3");
    idle(1);
    // R5 / R7 arithmetic left, sign kept, bits dropped
    issue(mk(2'b10, 2'd1), 16'h4001, 1'b1, "R5 sal1");
    issue(mk(2'b10, 2'd2), 16'hE000, 1'b0, "R5 sal2");
    issue(mk(2'b10, 2'd3), 16'h8FFF, 1'b1, "R7 sal3");
    // R6 / R7 arithmetic right
    issue(mk(2'b11, 2'd1), 16'h8000, 1'b1, "R6 sar1");
    issue(mk(2'b11, 2'd2), 16'h7FFC, 1'b0, "R6 sar2");
    issue(mk(2'b11, 2'd3), 16'hF00F, 1'b1, "R7 sar3");
    idle(3);
    // R8 zero count for each move
    for (int o = 0; o < 4; o++) issue(mk(2'(o), 2'd0), 16'hBEEF, 1'b1, "R8 cnt0");
    // R9 outside the group, R2 field decode
    issue(16'h0600 | 16'h0004 | 16'h0001, 16'h1357, 1'b0, "R9 bits3_2");
    issue(16'o003101, 16'h2468, 1'b1, "R9 wronggrp");
    issue(16'h0000, 16'hFFFF, 1'b0, "R9 zero");
    idle(2);
    // R2 / R10 sweep of all legal words, back to back
    for (int o = 0; o < 4; o++)
      for (int n = 1; n < 4; n++)
        issue(mk(2'(o), 2'(n)), 16'h9C31 ^ 16'(o * 777 + n * 91), 1'(n & 1), "R2 sweep");
    idle(4);
    quit = 1'b1;
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R10: %0d results missing, expected 0", q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule